// File: doc/BRIEF.md
# Segmented Byte-Memory Access Unit

This block turns a logical reference, made of a segment select and a 16-bit offset, into a 20-bit physical byte address. It then performs the access on a byte-wide synchronous memory held inside the block. It keeps four current segment base registers: code, data, stack and extra. A base is shifted left by four bits and the offset is added to it, so one base reaches a window of at most 64 KiB inside a 1 MiB address space.

A request selects one segment and gives an offset, a byte or word size, a read or write direction and the write data. The block touches one byte per clock cycle. A word is stored with its less significant byte at the computed address and its more significant byte one address above, wrapping at the top of the 20-bit space. A word access therefore takes two byte cycles. During these cycles `busy` blocks new requests and segment updates. A one-cycle `done` pulse marks completion. For a read, `done` comes with the assembled data.

Top module: `seg_mem_unit`

## Requirements
- R1: After reset, `busy`, `done`, `busStrobe` and `rdData` are 0, and all four segment bases are 0000h. A request with offset X then drives `busAddr` = X.
- R2: In the first byte cycle of an access, `busAddr` equals (base << 4) + offset modulo 2^20. Select code 0 picks code, 1 data, 2 stack and 3 extra.
- R3: A word write stores `reqWData[7:0]` at the computed address and `reqWData[15:8]` at the next address. A byte write stores only `reqWData[7:0]` and leaves the neighbouring byte unchanged.
- R4: The second byte cycle of a word access drives `busAddr` = first address + 1 modulo 2^20, so FFFFFh is followed by 00000h.
- R5: A word read returns {byte at address+1, byte at address}. A byte read returns {00h, byte at address}. Writes leave `rdData` unchanged.
- R6: An accepted request raises `busy` and `busStrobe` in the next cycle. A byte access strobes for one cycle and a word access for two cycles, low byte first. `busy` stays high until the cycle that carries `done`.
- R7: `done` is high for exactly one cycle, right after the last byte cycle, and `busy` is low in that cycle.
- R8: A request presented while `busy` is high is ignored. It changes neither the bus address nor the memory.
- R9: Segment bases load from `segWrData` only while `busy` is low. A load presented while `busy` is high is ignored.
- R10: Storage holds 2^MEM_AW bytes and is indexed by the low MEM_AW bits of the physical address, with MEM_AW = 10 by default. Physical addresses that are equal in those bits alias to the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| segWrEn | input | 1 | Load a segment base (honoured only when idle) |
| segWrSel | input | 2 | Base to load: 0 code, 1 data, 2 stack, 3 extra |
| segWrData | input | 16 | New segment base value |
| reqValid | input | 1 | Start an access (honoured only when idle) |
| reqSeg | input | 2 | Segment select of the access |
| reqOffset | input | 16 | Effective address within the segment |
| reqWord | input | 1 | 1 = 16-bit word, 0 = byte |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWData | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result, valid with `done` after a read |
| busStrobe | output | 1 | A byte cycle is taking place on the internal memory |
| busAddr | output | 20 | Physical address of the current byte cycle |

## Verification
The hardest cases to reach are the collisions with an access already in flight. One is a new request or a segment load arriving in the middle of a word access. The other is a word whose two halves straddle the FFFFFh/00000h boundary. For the first, the stimulus holds a conflicting write request and a data-segment load on the inputs for the whole second cycle of a word read. It then reads the targeted byte back and checks the address produced through the data segment. For the second, the extra-segment base is set to FFFFh and offsets 000Fh and 0020h are used. The wrapped halves are then read back through other segments that alias the same storage bytes.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } segSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchReq;  // capture address and write data
    logic loadSeg;   // segment load allowed this cycle
    logic accLo;     // low byte cycle
    logic accHi;     // high byte cycle
    logic doWrite;   // current byte cycle writes
    logic lastByte;  // current byte cycle ends the access
    logic inFlight;  // sequencer not idle
  } ctrlStrobe_t;

endpackage

// File: rtl/seg_mem_ctrl.sv
module seg_mem_ctrl
  import seg_mem_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWord,
  input  logic        reqWrite,
  input  logic        segWrEn,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done
);

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} state_e;

  state_e stateQ;
  logic   wordQ;
  logic   writeQ;
  logic   doneQ;

  always_comb begin
    strobe.latchReq = (stateQ == ST_IDLE) && reqValid;
    strobe.loadSeg  = (stateQ == ST_IDLE) && segWrEn;
    strobe.accLo    = (stateQ == ST_LO);
    strobe.accHi    = (stateQ == ST_HI);
    strobe.doWrite  = writeQ && (stateQ != ST_IDLE);
    strobe.lastByte = ((stateQ == ST_LO) && !wordQ) || (stateQ == ST_HI);
    strobe.inFlight = (stateQ != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      wordQ  <= 1'b0;
      writeQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= strobe.lastByte;
      unique case (stateQ)
        ST_IDLE: if (reqValid) begin
          stateQ <= ST_LO;
          wordQ  <= reqWord;
          writeQ <= reqWrite;
        end
        ST_LO:   stateQ <= wordQ ? ST_HI : ST_IDLE;
        ST_HI:   stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  // R6: acceptance raises busy next cycle
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);

  // R6: a word access always goes low byte then high byte
  p_word_two_cycles_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accLo && wordQ) |=> strobe.accHi);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: done only with busy low
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/seg_mem_datapath.sv
module seg_mem_datapath
  import seg_mem_pkg::*;
#(
  parameter int PHYS_W    = 20,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NUM_SEG   = 4,
  parameter int DATA_W    = 16,
  parameter int MEM_AW    = 10,
  localparam int SEL_W    = $clog2(NUM_SEG),
  localparam int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEL_W-1:0]  segWrSel,
  input  logic [OFF_W-1:0]  segWrData,
  input  logic [SEL_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqWData,
  output logic [DATA_W-1:0] rdData,
  output logic              busStrobe,
  output logic [PHYS_W-1:0] busAddr
);

  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [OFF_W-1:0]  segFile [NUM_SEG];
  logic [PHYS_W-1:0] physAddr;
  logic [PHYS_W-1:0] baseAddrQ;
  logic [DATA_W-1:0] wDataQ;
  logic [BYTE_W-1:0] loByteQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [BYTE_W-1:0] mem [MEM_DEPTH];
  logic [MEM_AW-1:0] memIdx;
  logic [BYTE_W-1:0] wrByte;
  logic [BYTE_W-1:0] rdByte;

  // segment base registers, one per select code
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        segFile[g] <= '0;
      else if (strobe.loadSeg && (segWrSel == SEL_W'(g)))
        segFile[g] <= segWrData;
    end

    // R9: bases frozen while an access is in flight
    p_seg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
      strobe.inFlight |=> $stable(segFile[g]));
  end

  // shifted base plus offset, truncated to the physical width
  always_comb begin
    physAddr = PHYS_W'({segFile[reqSeg], {SEG_SHIFT{1'b0}}})
             + PHYS_W'(reqOffset);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddrQ <= '0;
      wDataQ    <= '0;
    end else if (strobe.latchReq) begin
      baseAddrQ <= physAddr;
      wDataQ    <= reqWData;
    end
  end

  assign busStrobe = strobe.accLo || strobe.accHi;
  assign busAddr   = strobe.accHi ? (baseAddrQ + PHYS_W'(1)) : baseAddrQ;
  assign memIdx    = busAddr[MEM_AW-1:0];
  assign wrByte    = strobe.accHi ? wDataQ[2*BYTE_W-1:BYTE_W] : wDataQ[BYTE_W-1:0];
  assign rdByte    = mem[memIdx];

  always_ff @(posedge clk) begin
    if (busStrobe && strobe.doWrite)
      mem[memIdx] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByteQ <= '0;
      rdDataQ <= '0;
    end else if (busStrobe && !strobe.doWrite) begin
      if (strobe.accLo) begin
        loByteQ <= rdByte;
        if (strobe.lastByte)
          rdDataQ <= DATA_W'(rdByte);
      end
      if (strobe.accHi)
        rdDataQ <= {rdByte, loByteQ};
    end
  end

  assign rdData = rdDataQ;

  // R4: the high byte address follows the low one, wrapping at 2^PHYS_W
  p_hi_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accHi |-> (busAddr == PHYS_W'($past(busAddr) + 1'b1)));

  // R5: a write cycle leaves the read result alone
  p_write_keeps_rd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && strobe.doWrite) |=> $stable(rdData));

endmodule

// File: rtl/seg_mem_unit.sv
module seg_mem_unit
  import seg_mem_pkg::*;
#(
  parameter int PHYS_W    = 20,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NUM_SEG   = 4,
  parameter int DATA_W    = 16,
  parameter int MEM_AW    = 10,
  localparam int SEL_W    = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segWrEn,
  input  logic [SEL_W-1:0]  segWrSel,
  input  logic [OFF_W-1:0]  segWrData,
  input  logic              reqValid,
  input  logic [SEL_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              reqWord,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWData,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              busStrobe,
  output logic [PHYS_W-1:0] busAddr
);

  ctrlStrobe_t strobe;

  seg_mem_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWord  (reqWord),
    .reqWrite (reqWrite),
    .segWrEn  (segWrEn),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  seg_mem_datapath #(
    .PHYS_W    (PHYS_W),
    .OFF_W     (OFF_W),
    .SEG_SHIFT (SEG_SHIFT),
    .NUM_SEG   (NUM_SEG),
    .DATA_W    (DATA_W),
    .MEM_AW    (MEM_AW)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .segWrSel  (segWrSel),
    .segWrData (segWrData),
    .reqSeg    (reqSeg),
    .reqOffset (reqOffset),
    .reqWData  (reqWData),
    .rdData    (rdData),
    .busStrobe (busStrobe),
    .busAddr   (busAddr)
  );

endmodule

// File: tb/seg_mem_unit_tb.sv
module seg_mem_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSeg = '0;
  logic [15:0] reqOffset = '0;
  logic        reqWord = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWData = '0;
  logic        busy, done, busStrobe;
  logic [15:0] rdData;
  logic [19:0] busAddr;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  seg_mem_unit dut_i (.*);

  typedef struct packed {
    logic [1:0]  seg;
    logic [15:0] off;
    logic        word;
    logic        write;
    logic [15:0] wdata;
    logic [19:0] expAddr;
    logic [15:0] expRd;
  } vec_t;

  // segment bases: 0 code=0123h, 1 data=1000h, 2 stack=2000h, 3 extra=FFFFh
  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 16'h0002, 1'b1, 1'b1, 16'h1234, 20'h10002, 16'h0000}, // R3 word write
    '{2'd1, 16'h0002, 1'b0, 1'b0, 16'h0000, 20'h10002, 16'h0034}, // R3 low byte
    '{2'd1, 16'h0003, 1'b0, 1'b0, 16'h0000, 20'h10003, 16'h0012}, // R3 high byte
    '{2'd1, 16'h0002, 1'b1, 1'b0, 16'h0000, 20'h10002, 16'h1234}, // R5 word read
    '{2'd2, 16'h0105, 1'b1, 1'b1, 16'hABCD, 20'h20105, 16'h0000},
    '{2'd2, 16'h0105, 1'b0, 1'b0, 16'h0000, 20'h20105, 16'h00CD},
    '{2'd2, 16'h0106, 1'b0, 1'b0, 16'h0000, 20'h20106, 16'h00AB},
    '{2'd2, 16'h0105, 1'b1, 1'b0, 16'h0000, 20'h20105, 16'hABCD},
    '{2'd0, 16'h0010, 1'b0, 1'b1, 16'h005A, 20'h01240, 16'h0000},
    '{2'd0, 16'h0010, 1'b0, 1'b0, 16'h0000, 20'h01240, 16'h005A},
    '{2'd3, 16'h0020, 1'b1, 1'b1, 16'hBEEF, 20'h00010, 16'h0000}, // R2 sum wraps
    '{2'd1, 16'h0010, 1'b1, 1'b0, 16'h0000, 20'h10010, 16'hBEEF}, // R10 alias
    '{2'd3, 16'h000F, 1'b1, 1'b1, 16'h7788, 20'hFFFFF, 16'h0000}, // R4 wrap
    '{2'd2, 16'h0000, 1'b0, 1'b0, 16'h0000, 20'h20000, 16'h0077}, // R4 R10
    '{2'd3, 16'h000F, 1'b0, 1'b0, 16'h0000, 20'hFFFFF, 16'h0088},
    '{2'd1, 16'h0002, 1'b0, 1'b1, 16'h0099, 20'h10002, 16'h0000}, // R3 byte write
    '{2'd1, 16'h0002, 1'b1, 1'b0, 16'h0000, 20'h10002, 16'h1299}, // R3 neighbour kept
    '{2'd1, 16'h0040, 1'b0, 1'b1, 16'h0011, 20'h10040, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setSeg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrSel = sel; segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic doReq(input vec_t v, input logic chkRd);
    @(negedge clk);
    reqValid = 1'b1; reqSeg = v.seg; reqOffset = v.off;
    reqWord = v.word; reqWrite = v.write; reqWData = v.wdata;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R6 busy raised", 32'(busy), 32'd1);
    chk("R6 strobe lo", 32'(busStrobe), 32'd1);
    chk("R2 address", 32'(busAddr), 32'(v.expAddr));
    if (v.word) begin
      @(negedge clk);
      chk("R4 high address", 32'(busAddr), 32'(20'(v.expAddr + 20'd1)));
      chk("R6 busy word", 32'(busy), 32'd1);
    end
    @(negedge clk);
    chk("R7 done", 32'(done), 32'd1);
    chk("R7 busy low", 32'(busy), 32'd0);
    chk("R6 strobe off", 32'(busStrobe), 32'd0);
    if (chkRd && !v.write) chk("R3 R5 R10 read data", 32'(rdData), 32'(v.expRd));
    @(negedge clk);
    chk("R7 done drops", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 strobe", 32'(busStrobe), 32'd0);
    chk("R1 rdData", 32'(rdData), 32'd0);
    // R1: bases zero, so the physical address equals the offset
    v = '{2'd2, 16'h0123, 1'b0, 1'b0, 16'h0, 20'h00123, 16'h0};
    doReq(v, 1'b0);
    v = '{2'd3, 16'hFFFF, 1'b1, 1'b0, 16'h0, 20'h0FFFF, 16'h0};
    doReq(v, 1'b0);

    setSeg(2'd0, 16'h0123);
    setSeg(2'd1, 16'h1000);
    setSeg(2'd2, 16'h2000);
    setSeg(2'd3, 16'hFFFF);

    for (int i = 0; i < NVEC; i++) doReq(VECS[i], 1'b1);

    // R8 R9: conflicting request and segment load during a word read
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 2'd1; reqOffset = 16'h0002;
    reqWord = 1'b1; reqWrite = 1'b0;
    @(negedge clk);
    chk("R2 busy case address", 32'(busAddr), 32'h10002);
    reqValid = 1'b1; reqSeg = 2'd1; reqOffset = 16'h0040;
    reqWord = 1'b0; reqWrite = 1'b1; reqWData = 16'h00EE;
    segWrEn = 1'b1; segWrSel = 2'd1; segWrData = 16'h3000;
    @(negedge clk);
    chk("R8 address unaffected", 32'(busAddr), 32'h10003);
    chk("R6 busy held", 32'(busy), 32'd1);
    @(negedge clk);
    reqValid = 1'b0; segWrEn = 1'b0;
    chk("R7 done busy case", 32'(done), 32'd1);
    chk("R5 read busy case", 32'(rdData), 32'h1299);
    // R9 base unchanged, R8 ignored write never reached memory
    v = '{2'd1, 16'h0040, 1'b0, 1'b0, 16'h0, 20'h10040, 16'h0011};
    doReq(v, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule